// File: doc/BRIEF.md
# Alarm Indication Signal Detector

This block watches a received serial line, one bit per cycle in which a valid strobe is high, and decides whether the far end is sending the all-ones alarm indication signal. It counts the zero bits in fixed observation windows. At the end of each window it applies a set/clear rule to a status flag. The window length and the rule depend on the selected framing format.

For T1 and for E1 under the ITU rule, the flag has two-window hysteresis. Two consecutive quiet windows (few zeros) set it, and two consecutive busy windows clear it. For E1 under the ETSI rule, one quiet window sets the flag, but only while frame alignment is reported lost. The flag clears as soon as alignment returns or a busy window arrives. Each change of the flag is marked by a one-cycle pulse. A change of the format select restarts the detector from a clean state.

Top module: `ais_detector`

## Requirements
- R1: While `rst` is high on a clock edge, `ais_out` and `ais_chg` go low and the window position and zero history are cleared.
- R2: Only cycles with `bit_vld` high advance a window, and `bit_in` is ignored in other cycles. A T1 window (`mode_sel` = 2'b00) is 386 valid bits. The flag can only change at the edge that takes the last bit of a window, except under R7 and R8.
- R3: Under the paired rule (`mode_sel` 2'b00, 2'b10, 2'b11), the flag is set when a window ends holding two or fewer zeros and the window before it in the same format also held two or fewer zeros. A single quiet window does not set it.
- R4: Under the paired rule, the flag clears only when a window ends holding three or more zeros and the previous window also held three or more. Windows that alternate between quiet and busy leave the flag unchanged.
- R5: With `mode_sel` 2'b10 or 2'b11 (E1, ITU rule), a window is 512 valid bits.
- R6: With `mode_sel` 2'b01 (E1, ETSI rule), a window is 512 valid bits, and the flag is set at a window end that holds two or fewer zeros while `lof_in` is high.
- R7: With `mode_sel` 2'b01, the flag clears at a window end holding three or more zeros. It also clears at any edge where `lof_in` is low.
- R8: A change of `mode_sel` between two edges clears the flag, the window position and the window history at that edge. The bit presented in that cycle is discarded.
- R9: `ais_chg` is high for exactly the one cycle after each edge at which `ais_out` changes value, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Marks a cycle that carries a line bit |
| bit_in | input | 1 | Received line bit |
| mode_sel | input | 2 | Format: 00 T1, 01 E1 ETSI rule, 10/11 E1 ITU rule |
| lof_in | input | 1 | High while frame alignment is lost |
| ais_out | output | 1 | Alarm indication signal detected |
| ais_chg | output | 1 | One-cycle pulse on any change of `ais_out` |

## Verification
The assertions check properties that hold on every cycle. The window position stays inside the current window. The change pulse matches each toggle of the flag. A rise of the flag needs an accepted bit, and under the ETSI rule it also needs lost alignment. A format change or regained alignment leaves the flag low. Only the bench's scenarios can show the window lengths, the two-or-fewer versus three-or-more zero boundary, and the two-window hysteresis. They do this by comparing the flag against a bench model cycle by cycle, with directed windows at the boundaries and long random streams.

// File: rtl/ais_pkg.sv
package ais_pkg;

    typedef enum logic [1:0] {
        FMT_T1      = 2'b00,
        FMT_E1_ETSI = 2'b01,
        FMT_E1_ITU  = 2'b10,
        FMT_E1_ITUB = 2'b11
    } fmt_e;

    typedef enum logic {
        RULE_PAIR = 1'b0,
        RULE_LOF  = 1'b1
    } rule_e;

    typedef struct packed {
        logic done;
        logic quiet;
    } win_res_t;

    localparam logic [1:0] ZERO_SAT = 2'd3;

    function automatic logic [1:0] zero_inc(input logic [1:0] z, input logic b);
        return (z == ZERO_SAT || b) ? z : z + 2'd1;
    endfunction

    function automatic rule_e rule_of(input fmt_e f);
        return (f == FMT_E1_ETSI) ? RULE_LOF : RULE_PAIR;
    endfunction

    function automatic logic is_e1(input fmt_e f);
        return f != FMT_T1;
    endfunction

endpackage

// File: rtl/ais_win_cnt.sv
module ais_win_cnt
    import ais_pkg::*;
#(
    parameter int POS_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             bit_vld,
    input  logic             bit_in,
    input  logic [POS_W-1:0] last_idx,
    output win_res_t         res,
    output logic [POS_W-1:0] pos
);
    logic [POS_W-1:0] pos_q;
    logic [1:0]       zc_q;
    logic [1:0]       zc_nx;
    logic             at_end;

    always_comb begin
        zc_nx     = zero_inc(zc_q, bit_in);
        at_end    = (pos_q == last_idx);
        res.done  = bit_vld && !clr && at_end;
        res.quiet = (zc_nx != ZERO_SAT);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pos_q <= '0;
            zc_q  <= '0;
        end else if (bit_vld) begin
            if (at_end) begin
                pos_q <= '0;
                zc_q  <= '0;
            end else begin
                pos_q <= pos_q + 1'b1;
                zc_q  <= zc_nx;
            end
        end
    end

    assign pos = pos_q;

endmodule

// File: rtl/ais_rule.sv
module ais_rule
    import ais_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  rule_e    rule,
    input  win_res_t win,
    input  logic     lof,
    input  logic     ais_q,
    output logic     ais_nxt
);
    logic hist_vld;
    logic hist_quiet;

    always_comb begin
        ais_nxt = ais_q;
        if (clr) begin
            ais_nxt = 1'b0;
        end else begin
            unique case (rule)
                RULE_PAIR: begin
                    if (win.done && hist_vld) begin
                        if (win.quiet && hist_quiet)
                            ais_nxt = 1'b1;
                        else if (!win.quiet && !hist_quiet)
                            ais_nxt = 1'b0;
                    end
                end
                RULE_LOF: begin
                    if (!lof)
                        ais_nxt = 1'b0;
                    else if (win.done)
                        ais_nxt = win.quiet;
                end
                default: ais_nxt = ais_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hist_vld   <= 1'b0;
            hist_quiet <= 1'b0;
        end else if (win.done) begin
            hist_vld   <= 1'b1;
            hist_quiet <= win.quiet;
        end
    end

endmodule

// File: rtl/ais_detector.sv
module ais_detector
    import ais_pkg::*;
#(
    parameter int T1_WIN_BITS = 386,
    parameter int E1_WIN_BITS = 512
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_vld,
    input  logic       bit_in,
    input  logic [1:0] mode_sel,
    input  logic       lof_in,
    output logic       ais_out,
    output logic       ais_chg
);
    localparam int MAX_WIN = (T1_WIN_BITS > E1_WIN_BITS) ? T1_WIN_BITS : E1_WIN_BITS;
    localparam int POS_W   = (MAX_WIN > 2) ? $clog2(MAX_WIN) : 1;
    localparam logic [POS_W-1:0] T1_LAST = POS_W'(T1_WIN_BITS - 1);
    localparam logic [POS_W-1:0] E1_LAST = POS_W'(E1_WIN_BITS - 1);

    fmt_e             fmt_in;
    fmt_e             fmt_q;
    logic             mode_chg;
    logic [POS_W-1:0] last_idx;
    logic [POS_W-1:0] win_pos;
    win_res_t         win;
    logic             ais_q;
    logic             ais_nxt;
    logic             chg_q;

    assign fmt_in   = fmt_e'(mode_sel);
    assign mode_chg = (fmt_in != fmt_q);
    assign last_idx = is_e1(fmt_q) ? E1_LAST : T1_LAST;

    always_ff @(posedge clk) begin
        fmt_q <= fmt_in;
    end

    ais_win_cnt #(.POS_W(POS_W)) u_win (
        .clk      (clk),
        .rst      (rst),
        .clr      (mode_chg),
        .bit_vld  (bit_vld),
        .bit_in   (bit_in),
        .last_idx (last_idx),
        .res      (win),
        .pos      (win_pos)
    );

    ais_rule u_rule (
        .clk     (clk),
        .rst     (rst),
        .clr     (mode_chg),
        .rule    (rule_of(fmt_q)),
        .win     (win),
        .lof     (lof_in),
        .ais_q   (ais_q),
        .ais_nxt (ais_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ais_q <= 1'b0;
            chg_q <= 1'b0;
        end else begin
            ais_q <= ais_nxt;
            chg_q <= ais_nxt ^ ais_q;
        end
    end

    assign ais_out = ais_q;
    assign ais_chg = chg_q;

endmodule

// File: rtl/ais_detector_chk.sv
module ais_detector_chk #(
    parameter int POS_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             bit_vld,
    input logic [1:0]       mode_sel,
    input logic             lof_in,
    input logic             ais_out,
    input logic             ais_chg,
    input logic [POS_W-1:0] win_pos,
    input logic [POS_W-1:0] last_idx
);
    p_pos_in_window_r2: assert property (@(posedge clk) disable iff (rst)
        win_pos <= last_idx);

    p_rise_needs_bit_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ais_out) |-> $past(bit_vld));

    p_etsi_rise_lof_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(ais_out) && $past(mode_sel) == 2'b01) |-> $past(lof_in));

    p_etsi_regain_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b01 && !lof_in) |=> !ais_out);

    p_mode_change_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_sel != $past(mode_sel)) |=> !ais_out);

    p_chg_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        ais_chg == (ais_out != $past(ais_out)));

endmodule

bind ais_detector ais_detector_chk #(.POS_W(POS_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_vld  (bit_vld),
    .mode_sel (mode_sel),
    .lof_in   (lof_in),
    .ais_out  (ais_out),
    .ais_chg  (ais_chg),
    .win_pos  (win_pos),
    .last_idx (last_idx)
);

// File: tb/ais_detector_test.sv
`timescale 1ns/1ps
module ais_detector_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic       lof_in = 1'b0;
    logic       ais_out;
    logic       ais_chg;

    int n_checks = 0;
    int n_fail = 0;

    // reference model state
    int       m_pos, m_zc;
    bit       m_hv, m_hq, m_ais, m_chg;
    bit [1:0] m_mode;

    always #4 clk = ~clk;

    ais_detector uut (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
        .mode_sel(mode_sel), .lof_in(lof_in), .ais_out(ais_out), .ais_chg(ais_chg)
    );

    function automatic int win_len(input bit [1:0] md);
        return (md == 2'b00) ? 386 : 512;
    endfunction

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        n_checks++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model(input bit v, input bit b, input bit l, input bit [1:0] md);
        bit old, quiet, done;
        int z;
        old  = m_ais;
        done = 0;
        quiet = 0;
        if (md != m_mode) begin
            m_mode = md; m_pos = 0; m_zc = 0; m_hv = 0; m_hq = 0; m_ais = 0;
        end else begin
            if (v) begin
                z = m_zc + (b ? 0 : 1);
                if (z > 3) z = 3;
                quiet = (z <= 2);
                if (m_pos == win_len(md) - 1) begin
                    done = 1; m_pos = 0; m_zc = 0;
                end else begin
                    m_pos++; m_zc = z;
                end
            end
            if (md == 2'b01) begin
                if (!l) m_ais = 0;
                else if (done) m_ais = quiet;
            end else if (done && m_hv) begin
                if (quiet && m_hq) m_ais = 1;
                else if (!quiet && !m_hq) m_ais = 0;
            end
            if (done) begin m_hv = 1; m_hq = quiet; end
        end
        m_chg = (m_ais != old);
    endtask

    task automatic cyc(input bit v, input bit b, input bit l, input bit [1:0] md, input string tag);
        @(negedge clk);
        bit_vld = v; bit_in = b; lof_in = l; mode_sel = md;
        @(posedge clk);
        model(v, b, l, md);
        #1;
        check(ais_out == m_ais, {tag, " ais_out"}, ais_out, m_ais);
        check(ais_chg == m_chg, "R9 ais_chg", ais_chg, m_chg);
    endtask

    // one window of n valid bits, zeros spread every 50 bits; optional idle gaps
    task automatic win(input int n, input int zeros, input bit l, input bit [1:0] md,
                       input bit gaps, input string tag);
        int idx = 0;
        while (idx < n) begin
            if (gaps && ($urandom % 3 == 0)) begin
                cyc(1'b0, 1'b0, l, md, "R2");
            end else begin
                cyc(1'b1, !((idx % 50 == 0) && (idx / 50 < zeros)), l, md, tag);
                idx++;
            end
        end
    endtask

    task automatic do_reset(input bit [1:0] md);
        @(negedge clk);
        rst = 1; mode_sel = md; bit_vld = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        m_mode = md; m_pos = 0; m_zc = 0; m_hv = 0; m_hq = 0; m_ais = 0; m_chg = 0;
        #1;
        check(ais_out == 1'b0, "R1 reset ais_out", ais_out, 0);
        check(ais_chg == 1'b0, "R1 reset ais_chg", ais_chg, 0);
    endtask

    initial begin
        #1600000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        do_reset(2'b00);

        // T1 paired rule
        win(386, 0, 0, 2'b00, 0, "R3");
        check(ais_out == 0, "R3 single quiet window", ais_out, 0);
        win(386, 0, 0, 2'b00, 0, "R3");
        check(ais_out == 1, "R3 two quiet windows", ais_out, 1);
        win(386, 3, 0, 2'b00, 0, "R4");
        win(386, 2, 0, 2'b00, 0, "R4");
        check(ais_out == 1, "R4 alternating keeps set", ais_out, 1);
        win(386, 3, 0, 2'b00, 1, "R4");
        win(386, 3, 0, 2'b00, 0, "R4");
        check(ais_out == 0, "R4 two busy windows clear", ais_out, 0);
        win(386, 2, 0, 2'b00, 1, "R2");
        win(386, 2, 0, 2'b00, 1, "R3");
        check(ais_out == 1, "R3 two-zero boundary sets", ais_out, 1);

        // mode change clears
        cyc(1'b1, 1'b1, 0, 2'b10, "R8");
        check(ais_out == 0, "R8 mode change clear", ais_out, 0);

        // ITU E1 512-bit windows
        win(512, 0, 0, 2'b10, 0, "R5");
        win(511, 0, 0, 2'b10, 0, "R5");
        check(ais_out == 0, "R5 not before bit 512", ais_out, 0);
        cyc(1'b1, 1'b1, 0, 2'b10, "R5");
        check(ais_out == 1, "R5 set at bit 512", ais_out, 1);
        win(512, 3, 0, 2'b10, 0, "R4");
        win(512, 5, 0, 2'b10, 0, "R4");
        check(ais_out == 0, "R4 ITU clear", ais_out, 0);
        cyc(1'b1, 1'b1, 0, 2'b11, "R8");
        win(512, 1, 0, 2'b11, 0, "R5");
        win(512, 0, 0, 2'b11, 1, "R5");
        check(ais_out == 1, "R5 code 11 set", ais_out, 1);

        // ETSI E1 rule
        cyc(1'b1, 1'b1, 1, 2'b01, "R8");
        win(512, 0, 0, 2'b01, 0, "R6");
        check(ais_out == 0, "R6 aligned never sets", ais_out, 0);
        win(512, 1, 1, 2'b01, 0, "R6");
        check(ais_out == 1, "R6 one quiet window with lof", ais_out, 1);
        cyc(1'b0, 1'b1, 0, 2'b01, "R7");
        check(ais_out == 0, "R7 regain clears", ais_out, 0);
        win(512, 2, 1, 2'b01, 1, "R6");
        check(ais_out == 1, "R6 two zeros sets", ais_out, 1);
        win(512, 3, 1, 2'b01, 0, "R7");
        check(ais_out == 0, "R7 busy window clears", ais_out, 0);

        // random streams
        for (int i = 0; i < 30000; i++) begin
            bit [1:0] md = mode_sel;
            bit       l  = lof_in;
            if ($urandom % 4000 == 0) md = 2'($urandom);
            if ($urandom % 700 == 0) l = !l;
            cyc(($urandom % 5) != 0, ($urandom % 180) != 0, l, md, "R3/R6 random");
        end

        do_reset(2'b01);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule